// File: doc/BRIEF.md
# Ethernet Receive Address Filter and Frame Checker

This block sits behind a receive line decoder that already delivers NRZ bytes. While the carrier-active input is high it looks for the frame start. It drops the run of 0x55 preamble bytes and the 0xD5 delimiter. It then sends every later byte to an external receive buffer through a simple write port, and runs a CRC-32 over those bytes. The first six bytes form the destination address. These are tested against a programmed station address and four accept modes. A frame that fails the test, or that ends before its address is complete, is never committed: writing stops and the buffer pointer returns to where the frame began.

When the carrier drops, an accepted frame produces a one-cycle status report. The report gives the frame length, the buffer address of its first byte and whether the CRC was good. An interrupt pulse goes with the report, and two configuration bits choose whether good-CRC frames, bad-CRC frames or both raise it. A line that does not show a clean preamble and delimiter is ignored until the carrier drops again.

Top module: `erx_filter_top`

## Requirements
- R1: After reset, `buf_we`, `stat_valid` and `irq` are low, and the first accepted frame is stored from buffer address 0.
- R2: Preamble bytes (0x55) and the delimiter (0xD5) are never written. The first written byte is the first byte received after the delimiter.
- R3: A byte other than 0x55 or 0xD5 before the delimiter causes nothing to be written and no status until the carrier drops. The same holds when the carrier drops with no delimiter seen.
- R4: With `cfg_acc_unicast` set, a frame is accepted when its six destination bytes equal `cfg_station`, most significant byte first (the first received byte is compared with `cfg_station[47:40]`).
- R5: With `cfg_acc_bcast` set, a frame whose six destination bytes are all 0xFF is accepted.
- R6: With `cfg_acc_group` set, a frame is accepted when bit 0 of its first destination byte is 1.
- R7: With `cfg_promisc` set, every frame of at least six bytes is accepted.
- R8: A rejected frame has only its first six bytes written and gives no status. A frame shorter than six bytes gives no status either. The next accepted frame starts at the buffer address where the rejected frame started.
- R9: The CRC is the reflected CRC-32 (polynomial 0xEDB88320, preset all ones, each byte taken least significant bit first) over every byte from the destination address through the FCS. The FCS is good when the final register equals 0xDEBB20E3, which is the residue 0xC704DD7B in normal bit order. `stat_crc_ok` reports the result.
- R10: `stat_valid` pulses for one cycle, one cycle after the first clock edge at which the carrier is sampled low for an accepted frame. `stat_len` is the number of bytes from the destination through the FCS, and `stat_base` is the buffer address of the frame's first byte.
- R11: `irq` pulses together with `stat_valid` only when the CRC is good and `cfg_irq_good` is set, or when the CRC is bad and `cfg_irq_bad` is set.
- R12: Each stored byte appears on `buf_data` one cycle after it is sampled with `rx_valid` and `rx_active` high. Buffer addresses increase by one per byte and wrap at 2^AW. Cycles with `rx_valid` low inside a frame write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_active | input | 1 | Carrier present on the line |
| rx_valid | input | 1 | `rx_byte` holds a new byte this cycle |
| rx_byte | input | 8 | Decoded NRZ byte |
| cfg_station | input | 48 | Station address, first received byte in bits 47:40 |
| cfg_acc_unicast | input | 1 | Accept frames addressed to the station |
| cfg_acc_bcast | input | 1 | Accept all-ones destination |
| cfg_acc_group | input | 1 | Accept destinations with the group bit set |
| cfg_promisc | input | 1 | Accept every frame |
| cfg_irq_good | input | 1 | Interrupt on good-CRC frames |
| cfg_irq_bad | input | 1 | Interrupt on bad-CRC frames |
| buf_we | output | 1 | Buffer write strobe |
| buf_addr | output | AW | Buffer write address |
| buf_data | output | 8 | Buffer write data |
| stat_valid | output | 1 | Frame status pulse |
| stat_len | output | LEN_W | Frame length in bytes |
| stat_base | output | AW | Buffer address of the frame's first byte |
| stat_crc_ok | output | 1 | FCS matched |
| irq | output | 1 | Received-frame interrupt |

## Verification
The filter is tried with frames aimed at the station and with a frame whose sixth destination byte alone differs. This separates a full six-byte compare from a partial one. Broadcast, group-bit and promiscuous frames each run with only their own mode enabled, so a mode leaking into another shows up as an unexpected acceptance. A corrupted FCS, run once with each interrupt setting, separates the CRC result from the interrupt choice. A broken preamble, a preamble with no delimiter, a five-byte frame and an idle gap inside a frame cover framing, the short-frame rule and the write gating. Each frame after a rejection checks that the pointer rolled back.

// File: rtl/erx_pkg.sv
package erx_pkg;
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_DATA = 2'd1,
        ST_DROP = 2'd2
    } rx_state_e;

    localparam logic [7:0]  PRE_BYTE          = 8'h55;
    localparam logic [7:0]  SFD_BYTE          = 8'hD5;
    localparam logic [31:0] CRC_PRESET        = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_POLY_REFL     = 32'hEDB8_8320;
    localparam logic [31:0] CRC_RESIDUE_REFL  = 32'hDEBB_20E3;
    localparam int          ADDR_BYTES        = 6;
    localparam int          ADDR_IDX_W        = $clog2(ADDR_BYTES);
endpackage

// File: rtl/erx_crc32_step.sv
module erx_crc32_step
    import erx_pkg::*;
(
    input  logic [31:0] crc_i,
    input  logic [7:0]  data_i,
    output logic [31:0] crc_o
);
    logic [31:0] acc;

    always_comb begin
        acc = crc_i;
        for (int b = 0; b < 8; b++) begin
            if (acc[0] ^ data_i[b]) acc = (acc >> 1) ^ CRC_POLY_REFL;
            else                    acc = acc >> 1;
        end
        crc_o = acc;
    end
endmodule

// File: rtl/erx_addr_match.sv
module erx_addr_match
    import erx_pkg::*;
(
    input  logic [47:0]           station_i,
    input  logic [7:0]            byte_i,
    input  logic [ADDR_IDX_W-1:0] idx_i,
    input  logic                  eq_i,
    input  logic                  ff_i,
    input  logic                  grp_i,
    input  logic                  acc_unicast_i,
    input  logic                  acc_bcast_i,
    input  logic                  acc_group_i,
    input  logic                  promisc_i,
    output logic                  eq_o,
    output logic                  ff_o,
    output logic                  grp_o,
    output logic                  match_o
);
    localparam int SLOTS = 2 ** ADDR_IDX_W;

    logic [7:0] st_byte [SLOTS];

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_split
            if (g < ADDR_BYTES) begin : g_real
                assign st_byte[g] = station_i[47 - 8*g -: 8];
            end else begin : g_pad
                assign st_byte[g] = 8'h00;
            end
        end
    endgenerate

    logic first;
    logic hit;
    logic all1;

    always_comb begin
        first   = (idx_i == '0);
        hit     = (byte_i == st_byte[idx_i]);
        all1    = (byte_i == 8'hFF);
        eq_o    = first ? hit    : (eq_i & hit);
        ff_o    = first ? all1   : (ff_i & all1);
        grp_o   = first ? byte_i[0] : grp_i;
        match_o = promisc_i
                | (acc_unicast_i & eq_i)
                | (acc_bcast_i   & ff_i)
                | (acc_group_i   & grp_i);
    end
endmodule

// File: rtl/erx_filter_top.sv
module erx_filter_top
    import erx_pkg::*;
#(
    parameter int AW    = 11,
    parameter int LEN_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_active,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic [47:0]      cfg_station,
    input  logic             cfg_acc_unicast,
    input  logic             cfg_acc_bcast,
    input  logic             cfg_acc_group,
    input  logic             cfg_promisc,
    input  logic             cfg_irq_good,
    input  logic             cfg_irq_bad,
    output logic             buf_we,
    output logic [AW-1:0]    buf_addr,
    output logic [7:0]       buf_data,
    output logic             stat_valid,
    output logic [LEN_W-1:0] stat_len,
    output logic [AW-1:0]    stat_base,
    output logic             stat_crc_ok,
    output logic             irq
);
    localparam logic [LEN_W-1:0] LEN_MAX = '1;

    typedef struct packed {
        rx_state_e        st;
        logic [LEN_W-1:0] cnt;
        logic [31:0]      crc;
        logic             eq;
        logic             ff;
        logic             grp;
        logic [AW-1:0]    wptr;
        logic [AW-1:0]    base;
        logic             we;
        logic [AW-1:0]    waddr;
        logic [7:0]       wdata;
        logic             sv;
        logic [LEN_W-1:0] slen;
        logic [AW-1:0]    sbase;
        logic             sok;
        logic             irq;
    } regs_t;

    regs_t q, d;

    logic [31:0] crc_next;
    logic        eq_n, ff_n, grp_n, match;
    logic        in_addr;
    logic        byte_in;
    logic        crc_good;

    erx_crc32_step u_crc (
        .crc_i  (q.crc),
        .data_i (rx_byte),
        .crc_o  (crc_next)
    );

    erx_addr_match u_match (
        .station_i     (cfg_station),
        .byte_i        (rx_byte),
        .idx_i         (q.cnt[ADDR_IDX_W-1:0]),
        .eq_i          (q.eq),
        .ff_i          (q.ff),
        .grp_i         (q.grp),
        .acc_unicast_i (cfg_acc_unicast),
        .acc_bcast_i   (cfg_acc_bcast),
        .acc_group_i   (cfg_acc_group),
        .promisc_i     (cfg_promisc),
        .eq_o          (eq_n),
        .ff_o          (ff_n),
        .grp_o         (grp_n),
        .match_o       (match)
    );

    always_comb begin
        d        = q;
        d.we     = 1'b0;
        d.sv     = 1'b0;
        d.irq    = 1'b0;
        byte_in  = rx_valid && rx_active;
        in_addr  = (q.cnt < LEN_W'(ADDR_BYTES));
        crc_good = (q.crc == CRC_RESIDUE_REFL);

        unique case (q.st)
            ST_HUNT: begin
                if (byte_in) begin
                    if (rx_byte == SFD_BYTE) begin
                        d.st   = ST_DATA;
                        d.cnt  = '0;
                        d.crc  = CRC_PRESET;
                        d.wptr = q.base;
                    end else if (rx_byte != PRE_BYTE) begin
                        d.st = ST_DROP;
                    end
                end
            end
            ST_DROP: begin
                if (!rx_active) d.st = ST_HUNT;
            end
            ST_DATA: begin
                if (!rx_active) begin
                    d.st = ST_HUNT;
                    if (!in_addr && match) begin
                        d.sv    = 1'b1;
                        d.slen  = q.cnt;
                        d.sbase = q.base;
                        d.sok   = crc_good;
                        d.irq   = (crc_good & cfg_irq_good) | (~crc_good & cfg_irq_bad);
                        d.base  = q.wptr;
                    end else begin
                        d.wptr = q.base;
                    end
                end else if (rx_valid) begin
                    d.crc = crc_next;
                    if (q.cnt != LEN_MAX) d.cnt = q.cnt + 1'b1;
                    if (in_addr) begin
                        d.eq  = eq_n;
                        d.ff  = ff_n;
                        d.grp = grp_n;
                    end
                    if (in_addr || match) begin
                        d.we    = 1'b1;
                        d.waddr = q.wptr;
                        d.wdata = rx_byte;
                        d.wptr  = q.wptr + 1'b1;
                    end
                end
            end
            default: d.st = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign buf_we      = q.we;
    assign buf_addr    = q.waddr;
    assign buf_data    = q.wdata;
    assign stat_valid  = q.sv;
    assign stat_len    = q.slen;
    assign stat_base   = q.sbase;
    assign stat_crc_ok = q.sok;
    assign irq         = q.irq;
endmodule

// File: rtl/erx_filter_chk.sv
module erx_filter_chk #(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_active,
    input logic          rx_valid,
    input logic [7:0]    rx_byte,
    input logic          cfg_irq_good,
    input logic          cfg_irq_bad,
    input logic          buf_we,
    input logic [AW-1:0] buf_addr,
    input logic [7:0]    buf_data,
    input logic          stat_valid,
    input logic          stat_crc_ok,
    input logic          irq
);
    a_r12_write_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> $past(rx_valid && rx_active));

    a_r12_write_data_echo: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (buf_data == $past(rx_byte)));

    a_r12_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we && $past(buf_we)) |-> (buf_addr == AW'($past(buf_addr) + 1'b1)));

    a_r10_status_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> !$past(rx_active));

    a_r10_status_single: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |=> !stat_valid);

    a_r11_irq_with_status: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> stat_valid);

    a_r11_irq_choice: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat_crc_ok ? $past(cfg_irq_good) : $past(cfg_irq_bad)));
endmodule

bind erx_filter_top erx_filter_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_active    (rx_active),
    .rx_valid     (rx_valid),
    .rx_byte      (rx_byte),
    .cfg_irq_good (cfg_irq_good),
    .cfg_irq_bad  (cfg_irq_bad),
    .buf_we       (buf_we),
    .buf_addr     (buf_addr),
    .buf_data     (buf_data),
    .stat_valid   (stat_valid),
    .stat_crc_ok  (stat_crc_ok),
    .irq          (irq)
);

// File: tb/tb_erx_filter_top.sv
module tb_erx_filter_top;
    localparam int AW    = 11;
    localparam int LEN_W = 14;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rx_active = 1'b0, rx_valid = 1'b0;
    logic [7:0]       rx_byte = 8'h00;
    logic [47:0]      cfg_station = 48'h02_11_22_33_44_55;
    logic             cfg_acc_unicast = 1'b0, cfg_acc_bcast = 1'b0;
    logic             cfg_acc_group = 1'b0, cfg_promisc = 1'b0;
    logic             cfg_irq_good = 1'b1, cfg_irq_bad = 1'b0;
    logic             buf_we, stat_valid, stat_crc_ok, irq;
    logic [AW-1:0]    buf_addr, stat_base;
    logic [7:0]       buf_data;
    logic [LEN_W-1:0] stat_len;

    always #5 clk = ~clk;

    erx_filter_top #(.AW(AW), .LEN_W(LEN_W)) dut (.*);

    int n_chk = 0, n_bad = 0;
    int n_wr = 0, n_st = 0, n_irq = 0;
    int wr_addr [256];
    int wr_data [256];
    int st_len_s, st_base_s, st_ok_s;
    int exp_ptr = 0;
    logic [7:0] fr [256];
    int fr_n;

    always @(negedge clk) begin
        if (buf_we && n_wr < 256) begin
            wr_addr[n_wr] = int'(buf_addr);
            wr_data[n_wr] = int'(buf_data);
            n_wr++;
        end
        if (stat_valid) begin
            n_st++;
            st_len_s  = int'(stat_len);
            st_base_s = int'(stat_base);
            st_ok_s   = int'(stat_crc_ok);
        end
        if (irq) n_irq++;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_log();
        n_wr = 0; n_st = 0; n_irq = 0;
    endtask

    task automatic build(input logic [47:0] dest, input int pay, input bit bad_fcs);
        logic [31:0] c;
        for (int i = 0; i < 6; i++) fr[i] = dest[47 - 8*i -: 8];
        fr[6] = 8'h02; fr[7] = 8'h00; fr[8] = 8'h00;
        fr[9] = 8'h00; fr[10] = 8'h00; fr[11] = 8'h01;
        fr[12] = 8'h08; fr[13] = 8'h00;
        for (int i = 0; i < pay; i++) fr[14 + i] = 8'(i * 7 + 3);
        fr_n = 14 + pay;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < fr_n; i++)
            for (int b = 0; b < 8; b++)
                c = (c[0] ^ fr[i][b]) ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        c = ~c;
        for (int i = 0; i < 4; i++) fr[fr_n + i] = c[8*i +: 8];
        if (bad_fcs) fr[fr_n + 1] = fr[fr_n + 1] ^ 8'h10;
        fr_n = fr_n + 4;
    endtask

    task automatic drive(input logic [7:0] v);
        rx_active = 1'b1; rx_valid = 1'b1; rx_byte = v;
        @(negedge clk);
    endtask

    // mode 0: clean preamble; 1: broken preamble byte; 2: no delimiter
    task automatic send(input int mode, input int nbytes, input int gap_at);
        clear_log();
        @(negedge clk);
        for (int i = 0; i < 7; i++) drive((mode == 1 && i == 3) ? 8'h5A : 8'h55);
        if (mode != 2) begin
            drive(8'hD5);
            for (int i = 0; i < nbytes; i++) begin
                if (i == gap_at) begin
                    rx_valid = 1'b0; rx_byte = 8'hEE;
                    @(negedge clk);
                end
                drive(fr[i]);
            end
        end
        rx_valid = 1'b0; rx_active = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic check_accept(input string req, input int exp_ok, input int exp_irq);
        int mism = 0;
        chk(req, "status count", n_st, 1);
        chk(req, "stat_len", st_len_s, fr_n);
        chk(req, "stat_base", st_base_s, exp_ptr);
        chk(req, "stat_crc_ok", st_ok_s, exp_ok);
        chk(req, "irq count", n_irq, exp_irq);
        chk(req, "write count", n_wr, fr_n);
        for (int i = 0; i < n_wr && i < fr_n; i++) begin
            if (wr_data[i] != int'(fr[i])) mism++;
            if (wr_addr[i] != ((exp_ptr + i) % (1 << AW))) mism++;
        end
        chk({req, " R12"}, "data/address mismatches", mism, 0);
        exp_ptr = (exp_ptr + fr_n) % (1 << AW);
    endtask

    task automatic check_reject(input string req, input int exp_wr);
        chk(req, "status count", n_st, 0);
        chk(req, "irq count", n_irq, 0);
        chk(req, "write count", n_wr, exp_wr);
    endtask

    task automatic set_modes(input bit u, input bit b, input bit g, input bit p);
        cfg_acc_unicast = u; cfg_acc_bcast = b; cfg_acc_group = g; cfg_promisc = p;
    endtask

    task automatic t_reset();
        chk("R1", "buf_we", int'(buf_we), 0);
        chk("R1", "stat_valid", int'(stat_valid), 0);
        chk("R1", "irq", int'(irq), 0);
    endtask

    task automatic t_unicast();
        set_modes(1, 0, 0, 0);
        build(cfg_station, 46, 0);
        send(0, fr_n, -1);
        check_accept("R1 R2 R4 R9 R10", 1, 1);
    endtask

    task automatic t_unicast_miss();
        set_modes(1, 0, 0, 0);
        build(cfg_station ^ 48'h1, 30, 0);
        send(0, fr_n, -1);
        check_reject("R8 R4", 6);
    endtask

    task automatic t_broadcast();
        set_modes(0, 1, 0, 0);
        build(48'hFFFF_FFFF_FFFF, 50, 0);
        send(0, fr_n, 9);
        check_accept("R5 R8 R12", 1, 1);
        build(cfg_station, 20, 0);
        send(0, fr_n, -1);
        check_reject("R5", 6);
    endtask

    task automatic t_group();
        set_modes(0, 0, 1, 0);
        build(48'h01_00_5E_00_00_FB, 46, 0);
        send(0, fr_n, -1);
        check_accept("R6", 1, 1);
        build(48'h02_00_5E_00_00_FB, 46, 0);
        send(0, fr_n, -1);
        check_reject("R6", 6);
    endtask

    task automatic t_promisc();
        set_modes(0, 0, 0, 1);
        build(48'h0A_BB_CC_DD_EE_F0, 60, 0);
        send(0, fr_n, -1);
        check_accept("R7", 1, 1);
    endtask

    task automatic t_bad_crc();
        set_modes(1, 0, 0, 0);
        cfg_irq_good = 1'b1; cfg_irq_bad = 1'b0;
        build(cfg_station, 46, 1);
        send(0, fr_n, -1);
        check_accept("R9 R11", 0, 0);
        cfg_irq_good = 1'b0; cfg_irq_bad = 1'b1;
        build(cfg_station, 46, 1);
        send(0, fr_n, -1);
        check_accept("R11 bad", 0, 1);
        build(cfg_station, 46, 0);
        send(0, fr_n, -1);
        check_accept("R11 good", 1, 0);
        cfg_irq_good = 1'b1; cfg_irq_bad = 1'b0;
    endtask

    task automatic t_framing();
        set_modes(0, 0, 0, 1);
        build(cfg_station, 46, 0);
        send(1, fr_n, -1);
        check_reject("R3 broken preamble", 0);
        send(2, 0, -1);
        check_reject("R3 no delimiter", 0);
        send(0, 5, -1);
        check_reject("R8 short frame", 5);
        build(cfg_station, 46, 0);
        send(0, fr_n, -1);
        check_accept("R2 R8 after short", 1, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unicast();
        t_unicast_miss();
        t_broadcast();
        t_group();
        t_promisc();
        t_bad_crc();
        t_framing();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule